// File: doc/BRIEF.md
# Segment table translation unit

This block turns a logical address, given as a segment number plus an offset within that segment, into a physical address. The segment descriptors sit in an in-memory table. A base input gives the table's start address, and a length input gives how many segments are currently in use. The block accepts one request at a time. It rejects a segment number outside the table at once, without touching memory. For a legal number it reads the 64-bit descriptor through a request/grant/return-data handshake.

Once the descriptor has arrived, the block checks three things in turn: the descriptor's valid flag, whether the requested access type is allowed, and whether the offset lies inside the segment. If all three pass, it returns base plus offset. Otherwise it reports a trap with a 2-bit cause. Every result is held on the response port until the requester acknowledges it, and no new request is taken before that.

Top module: `seg_xlate`

## Requirements
- R1: While reset is asserted and just after it, `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0.
- R2: A request whose segment number is not less than `tbl_len` is answered with trap cause 0 and `rsp_paddr` 0, with no descriptor read (`mem_req` never rises for it).
- R3: For a legal segment number s, exactly one descriptor read is made, at byte address `tbl_base + 8*s`. `mem_req` and `mem_addr` are held until `mem_gnt`, and the descriptor is taken from `mem_rdata` on the first `mem_rvalid` after the grant.
- R4: Descriptor layout: bits 31..0 hold the segment base and bits 55..32 hold the segment length. Bit 56 is the valid flag, and bits 57, 58 and 59 grant read, write and execute. A descriptor with bit 56 clear traps with cause 1.
- R5: The access code is 0 for read, 1 for write, 2 for execute, and 3 for an access that no right permits. An access whose right bit is clear, or code 3, traps with cause 2.
- R6: An offset greater than or equal to the segment length traps with cause 3.
- R7: When several checks fail, the reported cause is the lowest-numbered one: invalid (1) before privilege (2) before length (3).
- R8: When no check fails, `rsp_trap` is 0, `rsp_cause` is 0, and `rsp_paddr` is (base + offset) modulo 2^32. On any trap, `rsp_paddr` is 0.
- R9: Once raised, `rsp_valid`, `rsp_trap`, `rsp_cause` and `rsp_paddr` stay unchanged until the cycle in which `rsp_ack` is sampled high. `req_ready` is 0 from acceptance until the cycle after that acknowledge, so requests offered meanwhile are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Block can take a request this cycle |
| req_seg | input | SEG_W | Segment number |
| req_off | input | 24 | Offset within the segment |
| req_acc | input | 2 | Access code (0 read, 1 write, 2 execute, 3 none) |
| tbl_base | input | 32 | Byte address of descriptor 0 |
| tbl_len | input | SEG_W+1 | Number of segments in use |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor byte address |
| mem_gnt | input | 1 | Memory accepted the read |
| mem_rvalid | input | 1 | Read data present |
| mem_rdata | input | 64 | Descriptor word |
| rsp_valid | output | 1 | Result present |
| rsp_ack | input | 1 | Requester takes the result |
| rsp_trap | output | 1 | Access refused |
| rsp_cause | output | 2 | Trap reason |
| rsp_paddr | output | 32 | Physical address |

## Verification
Two situations put two of the block's functions into the same cycle. In the first, one descriptor fails several checks at once. The table is built so that some entries are invalid, lack rights or have short lengths, and the offsets sweep across the length boundary, so every combination of failures reaches the priority logic. The reported cause is judged against the lowest failing check. In the second, a response is acknowledged in the same cycle that the next request is offered. The bench confirms that the new request is taken only once the block is idle again, and that its answer belongs to it.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
    localparam int ENT_W   = 64;
    localparam int BASE_W  = 32;
    localparam int LIM_W   = 24;
    localparam int LIM_LSB = 32;
    localparam int VLD_BIT = 56;
    localparam int RD_BIT  = 57;
    localparam int WR_BIT  = 58;
    localparam int EX_BIT  = 59;
    localparam int ENT_SHIFT = $clog2(ENT_W / 8);

    localparam logic [1:0] ACC_RD = 2'd0;
    localparam logic [1:0] ACC_WR = 2'd1;
    localparam logic [1:0] ACC_EX = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_CHECK = 2'd2,
        ST_RESP  = 2'd3
    } st_e;

    typedef enum logic [1:0] {
        CZ_RANGE   = 2'd0,
        CZ_INVALID = 2'd1,
        CZ_PRIV    = 2'd2,
        CZ_LIMIT   = 2'd3
    } cause_e;
endpackage

// File: rtl/seg_range_gate.sv
module seg_range_gate
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W = 4
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [SEG_W:0]    tbl_len,
    input  logic [BASE_W-1:0] tbl_base,
    output logic              legal,
    output logic [BASE_W-1:0] ent_addr
);
    always_comb begin
        legal    = ({1'b0, seg} < tbl_len);
        ent_addr = tbl_base + (BASE_W'(seg) << ENT_SHIFT);
    end
endmodule

// File: rtl/seg_entry_check.sv
module seg_entry_check
    import seg_xlate_pkg::*;
(
    input  logic [ENT_W-1:0]  entry,
    input  logic [LIM_W-1:0]  off,
    input  logic [1:0]        acc,
    output logic              fault,
    output cause_e            cause,
    output logic [BASE_W-1:0] paddr
);
    logic              allowed;
    logic [LIM_W-1:0]  seg_len;
    logic [BASE_W-1:0] seg_base;

    always_comb begin
        seg_base = entry[BASE_W-1:0];
        seg_len  = entry[LIM_LSB +: LIM_W];
        case (acc)
            ACC_RD:  allowed = entry[RD_BIT];
            ACC_WR:  allowed = entry[WR_BIT];
            ACC_EX:  allowed = entry[EX_BIT];
            default: allowed = 1'b0;
        endcase
        fault = 1'b1;
        if (!entry[VLD_BIT])      cause = CZ_INVALID;
        else if (!allowed)        cause = CZ_PRIV;
        else if (off >= seg_len)  cause = CZ_LIMIT;
        else begin
            fault = 1'b0;
            cause = CZ_RANGE;
        end
        paddr = seg_base + {{(BASE_W-LIM_W){1'b0}}, off};
    end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [LIM_W-1:0]  req_off,
    input  logic [1:0]        req_acc,
    input  logic [BASE_W-1:0] tbl_base,
    input  logic [SEG_W:0]    tbl_len,
    output logic              mem_req,
    output logic [BASE_W-1:0] mem_addr,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [ENT_W-1:0]  mem_rdata,
    output logic              rsp_valid,
    input  logic              rsp_ack,
    output logic              rsp_trap,
    output logic [1:0]        rsp_cause,
    output logic [BASE_W-1:0] rsp_paddr
);
    typedef struct packed {
        st_e               st;
        logic [SEG_W-1:0]  seg;
        logic [LIM_W-1:0]  off;
        logic [1:0]        acc;
        logic              granted;
        logic [ENT_W-1:0]  entry;
        logic              trap;
        cause_e            cause;
        logic [BASE_W-1:0] paddr;
    } regs_t;

    regs_t r_q, r_d;

    logic              gate_legal;
    logic [BASE_W-1:0] gate_addr;
    logic [SEG_W-1:0]  gate_seg;
    logic              chk_fault;
    cause_e            chk_cause;
    logic [BASE_W-1:0] chk_paddr;

    assign gate_seg = (r_q.st == ST_IDLE) ? req_seg : r_q.seg;

    seg_range_gate #(.SEG_W(SEG_W)) gate_i (
        .seg      (gate_seg),
        .tbl_len  (tbl_len),
        .tbl_base (tbl_base),
        .legal    (gate_legal),
        .ent_addr (gate_addr)
    );

    seg_entry_check check_i (
        .entry (r_q.entry),
        .off   (r_q.off),
        .acc   (r_q.acc),
        .fault (chk_fault),
        .cause (chk_cause),
        .paddr (chk_paddr)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.seg     = req_seg;
                    r_d.off     = req_off;
                    r_d.acc     = req_acc;
                    r_d.granted = 1'b0;
                    if (!gate_legal) begin
                        r_d.trap  = 1'b1;
                        r_d.cause = CZ_RANGE;
                        r_d.paddr = '0;
                        r_d.st    = ST_RESP;
                    end else begin
                        r_d.st    = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (!r_q.granted) begin
                    if (mem_gnt) r_d.granted = 1'b1;
                end else if (mem_rvalid) begin
                    r_d.entry = mem_rdata;
                    r_d.st    = ST_CHECK;
                end
            end
            ST_CHECK: begin
                r_d.trap  = chk_fault;
                r_d.cause = chk_cause;
                r_d.paddr = chk_fault ? '0 : chk_paddr;
                r_d.st    = ST_RESP;
            end
            default: begin
                if (rsp_ack) r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cause: CZ_RANGE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign mem_req   = (r_q.st == ST_FETCH) && !r_q.granted;
    assign mem_addr  = gate_addr;
    assign rsp_valid = (r_q.st == ST_RESP);
    assign rsp_trap  = r_q.trap;
    assign rsp_cause = r_q.cause;
    assign rsp_paddr = r_q.paddr;

    // R9
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ack |=> rsp_valid && $stable(rsp_trap)
            && $stable(rsp_cause) && $stable(rsp_paddr));

    // R9
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R2
    range_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ({1'b0, r_q.seg} < tbl_len));

    // R2
    range_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) && rsp_trap && rsp_cause == 2'd0 |-> $past(req_ready));

    // R3
    mem_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));

    // R8
    ok_paddr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_trap |-> rsp_paddr == '0);
endmodule

// File: tb/seg_xlate_tb_top.sv
`timescale 1ns/1ps
module seg_xlate_tb_top;
    localparam int SEG_W = 4;
    localparam int NSEG  = 1 << SEG_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [SEG_W-1:0] req_seg = '0;
    logic [23:0] req_off = '0;
    logic [1:0]  req_acc = '0;
    logic [31:0] tbl_base = 32'h0000_4000;
    logic [SEG_W:0] tbl_len = 5'd12;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_gnt;
    logic        mem_rvalid;
    logic [63:0] mem_rdata;
    logic        rsp_valid;
    logic        rsp_ack = 1'b0;
    logic        rsp_trap;
    logic [1:0]  rsp_cause;
    logic [31:0] rsp_paddr;

    int tot = 0;
    int bad = 0;
    int cyc = 0;
    int gnt_wait = 0;
    int wait_cnt = 0;
    int fetch_cnt = 0;
    logic [31:0] last_addr = '0;

    always #2.5 clk = ~clk;

    seg_xlate #(.SEG_W(SEG_W)) dut_i (
        .clk, .rst_n, .req_valid, .req_ready, .req_seg, .req_off, .req_acc,
        .tbl_base, .tbl_len, .mem_req, .mem_addr, .mem_gnt, .mem_rvalid,
        .mem_rdata, .rsp_valid, .rsp_ack, .rsp_trap, .rsp_cause, .rsp_paddr
    );

    function automatic logic [63:0] ent(int i);
        logic [31:0] b;
        logic [23:0] l;
        logic        v;
        logic [2:0]  p;
        b = 32'(32'hFFFF_FFF0 - i * 32'h0111_0000);
        l = 24'(24'h40 + i * 24'h1234);
        v = (i % 5) != 3;
        p = 3'((i * 3 + 1) & 7);
        return {4'b0, p[2], p[1], p[0], v, l, b};
    endfunction

    assign mem_gnt = mem_req && (wait_cnt >= gnt_wait);

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req && mem_gnt) begin
            int idx;
            idx = int'((mem_addr - tbl_base) >> 3);
            fetch_cnt  <= fetch_cnt + 1;
            last_addr  <= mem_addr;
            mem_rvalid <= 1'b1;
            mem_rdata  <= (idx >= 0 && idx < NSEG) ? ent(idx) : 64'h0;
            wait_cnt   <= 0;
        end else if (mem_req) begin
            wait_cnt <= wait_cnt + 1;
        end else begin
            wait_cnt <= 0;
        end
    end

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        tot++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run(int seg, int off, int acc, int ackd, bit ovl);
        logic [63:0] e;
        logic [23:0] lim;
        bit vld, allowed, et;
        logic [1:0] ec;
        logic [31:0] ep;
        int nv, f0, w;
        bit acc_now, legal;
        string tag;
        logic [34:0] held;
        e = ent(seg);
        lim = e[55:32];
        vld = e[56];
        allowed = (acc == 0) ? e[57] : (acc == 1) ? e[58] : (acc == 2) ? e[59] : 1'b0;
        legal = seg < int'(tbl_len);
        nv = 0;
        if (!vld) nv++;
        if (!allowed) nv++;
        if (24'(off) >= lim) nv++;
        et = 1'b1; ep = '0;
        if (!legal)              begin ec = 2'd0; tag = "R2"; end
        else if (!vld)           begin ec = 2'd1; tag = "R4"; end
        else if (!allowed)       begin ec = 2'd2; tag = "R5"; end
        else if (24'(off) >= lim) begin ec = 2'd3; tag = "R6"; end
        else begin
            et = 1'b0; ec = 2'd0; tag = "R8";
            ep = e[31:0] + {8'h0, 24'(off)};
        end
        if (legal && nv > 1) tag = "R7";
        f0 = fetch_cnt;
        req_valid = 1'b1;
        req_seg = SEG_W'(seg);
        req_off = 24'(off);
        req_acc = 2'(acc);
        forever begin
            acc_now = req_ready;
            @(negedge clk);
            rsp_ack = 1'b0;
            if (acc_now) break;
        end
        req_valid = 1'b0;
        w = 0;
        while (!rsp_valid && w < 60) begin @(negedge clk); w++; end
        chk(rsp_valid, "R9", "response missing", 64'(rsp_valid), 64'd1);
        chk({rsp_trap, rsp_cause, rsp_paddr} == {et, ec, ep}, tag, "result",
            64'({rsp_trap, rsp_cause, rsp_paddr}), 64'({et, ec, ep}));
        chk((fetch_cnt - f0) == (legal ? 1 : 0), legal ? "R3" : "R2", "read count",
            64'(fetch_cnt - f0), legal ? 64'd1 : 64'd0);
        if (legal)
            chk(last_addr == tbl_base + 32'(seg * 8), "R3", "read address",
                64'(last_addr), 64'(tbl_base + 32'(seg * 8)));
        held = {rsp_trap, rsp_cause, rsp_paddr};
        for (int k = 0; k < ackd; k++) begin
            @(negedge clk);
            chk(rsp_valid && !req_ready && {rsp_trap, rsp_cause, rsp_paddr} == held,
                "R9", "held response", 64'({rsp_valid, req_ready, rsp_trap, rsp_cause, rsp_paddr}),
                64'({2'b10, held}));
        end
        rsp_ack = 1'b1;
        if (!ovl) begin
            @(negedge clk);
            rsp_ack = 1'b0;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            tot++;
            bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", tot, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk(req_ready && !rsp_valid && !mem_req, "R1", "in reset",
            64'({req_ready, rsp_valid, mem_req}), 64'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_req, "R1", "after reset",
            64'({req_ready, rsp_valid, mem_req}), 64'b100);
        for (int pass = 0; pass < 2; pass++) begin
            tbl_base = (pass == 0) ? 32'h0000_4000 : 32'h8000_0100;
            tbl_len  = (pass == 0) ? 5'd12 : 5'd16;
            for (int s = 0; s < NSEG; s++)
                for (int a = 0; a < 4; a++)
                    for (int k = 0; k < 4; k++) begin
                        logic [23:0] lim;
                        int off;
                        lim = ent(s)[55:32];
                        off = (k == 0) ? 0 : (k == 1) ? int'(lim) - 1 :
                              (k == 2) ? int'(lim) : int'(lim) + 37;
                        gnt_wait = (s + k) % 3;
                        run(s, off, a, k % 3, (a == 3) && !(pass == 1 && s == NSEG - 1 && k == 3));
                    end
        end
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", tot, bad);
        $finish;
    end
endmodule